// File: doc/BRIEF.md
# Pipelined Cartesian-to-Polar Converter

This block turns a signed pair of coordinates (x, y) into a magnitude and a full-circle angle. It uses a vectoring CORDIC that is fully pipelined, so it accepts a new sample on every clock and returns each result a fixed number of cycles later. The front end takes the absolute values of x and y, and may also exchange them, so that every point lies between 0 and 45 degrees. A chain of shift-add micro-rotations then drives y toward zero while it accumulates the angle. The back end removes the CORDIC gain with a few shifted adds and maps the angle back to the octant the point came from.

The angle is an unsigned 20-bit binary fraction of a turn, counted counter-clockwise from the positive x axis: 0x40000 is a quarter turn and 0x80000 is a half turn. The magnitude carries four fractional bits, so it reads as sixteen times the Euclidean length. A valid strobe travels alongside the data. The content of the outputs is defined only while the output valid is high.

Top module: `cordic_polar`

## Requirements
- R1: A sample accepted with `inVld` high produces `outVld` high exactly 20 clocks later. `outVld` is low in every cycle that has no accepted sample 20 clocks earlier. Back-to-back samples and gapped samples are both handled, at one sample per clock.
- R2: `outMag` is within 16 + E/1000 of E, where E = 16·sqrt(x²+y²), rounded.
- R3: `outAng` is within 24 + 128000/sqrt(x²+y²) units of round(atan2(y, x)·2^20/2π) mod 2^20. The difference is taken modulo 2^20. This holds in all eight octants, including points where |x| = |y|.
- R4: A point on an axis lands on that axis. +y gives 0x40000, -x gives 0x80000 and -y gives 0xC0000, each within the R3 tolerance.
- R5: The input (0, 0) gives `outMag` = 0 and `outAng` = 0 exactly.
- R6: The input value -32768 on either coordinate is treated as a length of 32767 and does not overflow. The results still meet R2 and R3, and bit 20 of `outMag` is never set.
- R7: While reset is applied, and after it, `outVld`, `outMag` and `outAng` are all 0 until the first sample emerges.
- R8: A point on the positive x axis gives an angle below 0x01000. A small negative residual left by the iterations is clamped to zero and never wraps to just under a full turn.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inVld | input | 1 | Input sample valid |
| inX | input | 16 | Signed x coordinate |
| inY | input | 16 | Signed y coordinate |
| outVld | output | 1 | Result valid, 20 clocks after `inVld` |
| outMag | output | 21 | Magnitude × 16, unsigned |
| outAng | output | 20 | Angle, 2^20 units per turn |

## Verification
Each result is due 20 clocks after its sample: 2 clocks for the fold, 15 for the rotations and 3 for the gain and unfold. The bench drives a sample on a falling edge and compares the outputs on the falling edge 20 clocks later, using its own real-valued atan2 and square-root model. Every cycle of a burst, including the idle slots inside a gapped stream, is checked for the expected level of `outVld`. The values and the valid level of the axis, zero and extreme-value cases are checked in that same slot.

// File: rtl/cordic_polar_pkg.sv
`timescale 1ns/1ps
package cordic_polar_pkg;
  parameter int DATA_W = 16;
  parameter int FRAC_W = 4;
  parameter int GUARD_W = 2;
  parameter int ITER_N = 15;
  parameter int ANG_W = 20;
  parameter int FRONT_LAT = 2;
  parameter int BACK_LAT = 3;
  localparam int CORE_W = DATA_W + FRAC_W + GUARD_W;
  localparam int MAG_W = DATA_W + FRAC_W + 1;
  localparam int TOTAL_LAT = FRONT_LAT + ITER_N + BACK_LAT;

  typedef struct packed {
    logic                  load;
    logic [FRONT_LAT-1:0]  front;
    logic [ITER_N-1:0]     iter;
    logic [BACK_LAT-2:0]   back;
  } strobes_t;

  typedef struct packed {
    logic zero;
    logic yNeg;
    logic xNeg;
    logic swap;
  } foldFlags_t;

  // arctan(2^-n) in units of 2^-20 turn, rounded
  function automatic logic [ANG_W-1:0] atanStep(input int n);
    int v;
    case (n)
      0: v = 131072;  1: v = 77376;  2: v = 40884;  3: v = 20753;
      4: v = 10417;   5: v = 5213;   6: v = 2607;   7: v = 1304;
      8: v = 652;     9: v = 326;    10: v = 163;   11: v = 81;
      12: v = 41;     13: v = 20;    14: v = 10;    15: v = 5;
      16: v = 3;      17: v = 1;     18: v = 1;
      default: v = 0;
    endcase
    return ANG_W'(v);
  endfunction
endpackage

// File: rtl/cordic_polar_ctrl.sv
`timescale 1ns/1ps
module cordic_polar_ctrl
  import cordic_polar_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     inVld,
  output strobes_t stb,
  output logic     outVld
);
  logic [FRONT_LAT-1:0] frontVld;
  logic [ITER_N-1:0]    iterVld;
  logic [BACK_LAT-2:0]  backVld;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frontVld <= '0;
      iterVld  <= '0;
      backVld  <= '0;
      outVld   <= 1'b0;
    end else begin
      frontVld <= {frontVld[FRONT_LAT-2:0], inVld};
      iterVld  <= {iterVld[ITER_N-2:0], frontVld[FRONT_LAT-1]};
      backVld  <= {backVld[BACK_LAT-3:0], iterVld[ITER_N-1]};
      outVld   <= backVld[BACK_LAT-2];
    end
  end

  always_comb begin
    stb.load  = inVld;
    stb.front = frontVld;
    stb.iter  = iterVld;
    stb.back  = backVld;
  end
endmodule

// File: rtl/cordic_polar_dp.sv
`timescale 1ns/1ps
module cordic_polar_dp
  import cordic_polar_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  strobes_t           stb,
  input  logic [DATA_W-1:0]  inX,
  input  logic [DATA_W-1:0]  inY,
  output logic [MAG_W-1:0]   outMag,
  output logic [ANG_W-1:0]   outAng
);
  localparam logic [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] MOST_POS = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [ANG_W-1:0]  QUARTER  = ANG_W'(1) << (ANG_W-2);
  localparam logic [ANG_W-1:0]  HALF     = ANG_W'(1) << (ANG_W-1);

  function automatic logic [DATA_W-1:0] satAbs(input logic [DATA_W-1:0] v);
    if (v == MOST_NEG) return MOST_POS;
    else if (v[DATA_W-1]) return -v;
    else return v;
  endfunction

  // fold stage 1: absolute values and signs
  logic [DATA_W-1:0] absX, absY;
  logic              sgnX, sgnY;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      absX <= '0; absY <= '0; sgnX <= 1'b0; sgnY <= 1'b0;
    end else if (stb.load) begin
      absX <= satAbs(inX);
      absY <= satAbs(inY);
      sgnX <= inX[DATA_W-1];
      sgnY <= inY[DATA_W-1];
    end
  end

  // fold stage 2: order the pair so that x >= y
  logic [DATA_W-1:0] foldX, foldY;
  foldFlags_t        foldFlags;
  logic              needSwap;
  assign needSwap = absY > absX;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      foldX <= '0; foldY <= '0; foldFlags <= '0;
    end else if (stb.front[0]) begin
      foldX <= needSwap ? absY : absX;
      foldY <= needSwap ? absX : absY;
      foldFlags.zero <= (absX == '0) && (absY == '0);
      foldFlags.yNeg <= sgnY;
      foldFlags.xNeg <= sgnX;
      foldFlags.swap <= needSwap;
    end
  end

  // micro-rotation chain
  logic signed [CORE_W-1:0] cx [0:ITER_N];
  logic signed [CORE_W-1:0] cy [0:ITER_N];
  logic        [ANG_W-1:0]  cz [0:ITER_N];
  foldFlags_t               cf [0:ITER_N];
  logic [ITER_N-1:0]        iterLoad;

  assign cx[0] = {{GUARD_W{1'b0}}, foldX, {FRAC_W{1'b0}}};
  assign cy[0] = {{GUARD_W{1'b0}}, foldY, {FRAC_W{1'b0}}};
  assign cz[0] = '0;
  assign cf[0] = foldFlags;
  assign iterLoad = {stb.iter[ITER_N-2:0], stb.front[FRONT_LAT-1]};

  for (genvar i = 0; i < ITER_N; i++) begin : g_iter
    localparam logic [ANG_W-1:0] STEP = atanStep(i);
    logic signed [CORE_W-1:0] xr, yr;
    logic        [ANG_W-1:0]  zr;
    foldFlags_t               fr;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        xr <= '0; yr <= '0; zr <= '0; fr <= '0;
      end else if (iterLoad[i]) begin
        if (!cy[i][CORE_W-1]) begin
          xr <= cx[i] + (cy[i] >>> i);
          yr <= cy[i] - (cx[i] >>> i);
          zr <= cz[i] + STEP;
        end else begin
          xr <= cx[i] - (cy[i] >>> i);
          yr <= cy[i] + (cx[i] >>> i);
          zr <= cz[i] - STEP;
        end
        fr <= cf[i];
      end
    end
    assign cx[i+1] = xr;
    assign cy[i+1] = yr;
    assign cz[i+1] = zr;
    assign cf[i+1] = fr;
  end

  // back stage 1: partial gain sums, clamp, undo exchange
  logic signed [CORE_W-1:0] gainA, gainB, gainC;
  logic [ANG_W-1:0]         angA, angB, angRes;
  logic [ANG_W-1:0]         angIn;
  logic                     bXNeg, bYNeg, cYNeg;
  foldFlags_t               endFlags;
  assign endFlags = cf[ITER_N];
  assign angIn = cz[ITER_N][ANG_W-1] ? '0 : cz[ITER_N];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gainA <= '0; gainB <= '0; angA <= '0; bXNeg <= 1'b0; bYNeg <= 1'b0;
    end else if (stb.iter[ITER_N-1]) begin
      gainA <= (cx[ITER_N] >>> 1) + (cx[ITER_N] >>> 3);
      gainB <= (cx[ITER_N] >>> 6) + (cx[ITER_N] >>> 9);
      if (endFlags.zero)      angA <= '0;
      else if (endFlags.swap) angA <= QUARTER - angIn;
      else                    angA <= angIn;
      bXNeg <= endFlags.xNeg;
      bYNeg <= endFlags.yNeg;
    end
  end

  // back stage 2: combine gain terms, undo x sign
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gainC <= '0; angB <= '0; cYNeg <= 1'b0;
    end else if (stb.back[0]) begin
      gainC <= gainA - gainB;
      angB  <= bXNeg ? (HALF - angA) : angA;
      cYNeg <= bYNeg;
    end
  end

  // back stage 3: final gain trim, undo y sign
  logic signed [CORE_W-1:0] gainTrim;
  assign gainTrim = gainC - (gainC >>> 12);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outMag <= '0; angRes <= '0;
    end else if (stb.back[1]) begin
      outMag <= MAG_W'(gainTrim);
      angRes <= cYNeg ? (ANG_W'(0) - angB) : angB;
    end
  end
  assign outAng = angRes;
endmodule

// File: rtl/cordic_polar.sv
`timescale 1ns/1ps
module cordic_polar
  import cordic_polar_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               inVld,
  input  logic [DATA_W-1:0]  inX,
  input  logic [DATA_W-1:0]  inY,
  output logic               outVld,
  output logic [MAG_W-1:0]   outMag,
  output logic [ANG_W-1:0]   outAng
);
  strobes_t stb;

  cordic_polar_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .inVld  (inVld),
    .stb    (stb),
    .outVld (outVld)
  );

  cordic_polar_dp u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .inX    (inX),
    .inY    (inY),
    .outMag (outMag),
    .outAng (outAng)
  );
endmodule

// File: rtl/cordic_polar_chk.sv
`timescale 1ns/1ps
module cordic_polar_chk
  import cordic_polar_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               inVld,
  input logic [DATA_W-1:0]  inX,
  input logic [DATA_W-1:0]  inY,
  input logic               outVld,
  input logic [MAG_W-1:0]   outMag,
  input logic [ANG_W-1:0]   outAng
);
  logic [TOTAL_LAT-1:0] dVld, dZero, dPosX, dNegX;
  logic inZero, inPosX, inNegX;
  assign inZero = (inX == '0) && (inY == '0);
  assign inPosX = (inY == '0) && !inX[DATA_W-1] && (inX != '0);
  assign inNegX = (inY == '0) && inX[DATA_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dVld <= '0; dZero <= '0; dPosX <= '0; dNegX <= '0;
    end else begin
      dVld  <= {dVld[TOTAL_LAT-2:0], inVld};
      dZero <= {dZero[TOTAL_LAT-2:0], inVld && inZero};
      dPosX <= {dPosX[TOTAL_LAT-2:0], inVld && inPosX};
      dNegX <= {dNegX[TOTAL_LAT-2:0], inVld && inNegX};
    end
  end

  // R1
  latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    outVld == dVld[TOTAL_LAT-1]);

  // R5
  zero_input_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outVld && dZero[TOTAL_LAT-1]) |-> (outMag == '0 && outAng == '0));

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    outVld |-> !outMag[MAG_W-1]);

  // R4
  neg_axis_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outVld && dNegX[TOTAL_LAT-1]) |-> (outAng >= 20'h7F000 && outAng <= 20'h81000));

  // R8
  pos_axis_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outVld && dPosX[TOTAL_LAT-1]) |-> (outAng < 20'h01000));
endmodule

bind cordic_polar cordic_polar_chk u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .inVld  (inVld),
  .inX    (inX),
  .inY    (inY),
  .outVld (outVld),
  .outMag (outMag),
  .outAng (outAng)
);

// File: tb/cordic_polar_bench.sv
`timescale 1ns/1ps
module cordic_polar_bench;
  localparam int LAT = 20;
  localparam real TWO_PI = 6.283185307179586;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inVld = 1'b0;
  logic [15:0] inX = '0, inY = '0;
  logic outVld;
  logic [20:0] outMag;
  logic [19:0] outAng;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  int bx [0:63];
  int by [0:63];
  bit bv [0:63];
  int gotAng [0:63];
  int nVec;

  always #2 clk = ~clk;

  cordic_polar u_cordic_polar (
    .clk(clk), .rstN(rstN), .inVld(inVld), .inX(inX), .inY(inY),
    .outVld(outVld), .outMag(outMag), .outAng(outAng)
  );

  task automatic checkVal(input string tag, input int act, input int exp, input int tol,
                          input bit modular);
    int d;
    d = act - exp;
    if (modular) begin
      if (d > 524288) d -= 1048576;
      if (d < -524288) d += 1048576;
    end
    if (d < 0) d = -d;
    checks++;
    if (d > tol) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d tol=%0d", tag, act, exp, tol);
    end
  endtask

  task automatic checkResult(input int idx);
    real r, a, em;
    int ea, eMag, tolA, tolM;
    r = $sqrt(real'(bx[idx])*real'(bx[idx]) + real'(by[idx])*real'(by[idx]));
    if (bx[idx] == 0 && by[idx] == 0) begin
      checkVal("R5 magnitude", int'(outMag), 0, 0, 0);
      checkVal("R5 angle", int'(outAng), 0, 0, 0);
      return;
    end
    a = $atan2(real'(by[idx]), real'(bx[idx]));
    if (a < 0.0) a += TWO_PI;
    ea = $rtoi(a / TWO_PI * 1048576.0 + 0.5);
    if (ea >= 1048576) ea -= 1048576;
    em = 16.0 * r;
    eMag = $rtoi(em + 0.5);
    tolM = 16 + eMag / 1000;
    tolA = 24 + $rtoi(128000.0 / r);
    checkVal("R2 magnitude", int'(outMag), eMag, tolM, 0);
    checkVal("R3 angle", int'(outAng), ea, tolA, 1);
  endtask

  // Drive vectors on falling edges and compare each slot LAT clocks later
  task automatic runBatch();
    for (int t = 0; t < nVec + LAT; t++) begin
      @(negedge clk);
      if (t >= LAT) begin
        checkVal("R1 output valid", int'(outVld), int'(bv[t-LAT]), 0, 0);
        if (bv[t-LAT]) begin
          checkResult(t - LAT);
          gotAng[t-LAT] = int'(outAng);
        end
      end
      if (t < nVec) begin
        inVld = bv[t];
        inX = 16'(bx[t]);
        inY = 16'(by[t]);
      end else begin
        inVld = 1'b0;
        inX = '0;
        inY = '0;
      end
    end
  endtask

  task automatic addVec(input int x, input int y, input bit v);
    bx[nVec] = x; by[nVec] = y; bv[nVec] = v; gotAng[nVec] = 0;
    nVec++;
  endtask

  task automatic testReset();
    // R7: outputs stay 0 during and right after reset
    checkVal("R7 valid in reset", int'(outVld), 0, 0, 0);
    checkVal("R7 magnitude in reset", int'(outMag), 0, 0, 0);
    checkVal("R7 angle in reset", int'(outAng), 0, 0, 0);
    @(negedge clk); rstN = 1'b1;
    repeat (3) @(negedge clk);
    checkVal("R7 valid after reset", int'(outVld), 0, 0, 0);
    checkVal("R7 magnitude after reset", int'(outMag), 0, 0, 0);
  endtask

  task automatic testOctants();
    // R3: one point per octant, plus diagonal ties
    nVec = 0;
    addVec(20000, 7000, 1);  addVec(7000, 20000, 1);
    addVec(-7000, 20000, 1); addVec(-20000, 7000, 1);
    addVec(-20000, -7000, 1); addVec(-7000, -20000, 1);
    addVec(7000, -20000, 1); addVec(20000, -7000, 1);
    addVec(9000, 9000, 1);   addVec(-9000, -9000, 1);
    addVec(-9000, 9000, 1);  addVec(3, 4, 1);
    runBatch();
  endtask

  task automatic testAxes();
    // R4 and R8: axis points
    nVec = 0;
    addVec(12000, 0, 1); addVec(0, 12000, 1);
    addVec(-12000, 0, 1); addVec(0, -12000, 1);
    addVec(5, 0, 1); addVec(0, -5, 1);
    runBatch();
    checkVal("R4 +y axis", gotAng[1], 262144, 30, 1);
    checkVal("R4 -x axis", gotAng[2], 524288, 30, 1);
    checkVal("R4 -y axis", gotAng[3], 786432, 30, 1);
    checks++;
    if (gotAng[0] >= 4096) begin
      fails++;
      $display("FAIL R8 +x axis angle actual=%0d expected below 4096", gotAng[0]);
    end
    checks++;
    if (gotAng[4] >= 4096) begin
      fails++;
      $display("FAIL R8 small +x axis angle actual=%0d expected below 4096", gotAng[4]);
    end
  endtask

  task automatic testZero();
    // R5: origin between ordinary samples
    nVec = 0;
    addVec(1000, 1000, 1); addVec(0, 0, 1); addVec(-1500, 200, 1); addVec(0, 0, 1);
    runBatch();
  endtask

  task automatic testExtremes();
    // R6: most negative code saturates
    nVec = 0;
    addVec(-32768, 0, 1); addVec(0, -32768, 1);
    addVec(-32768, -32768, 1); addVec(32767, 32767, 1);
    addVec(32767, -32768, 1); addVec(-32768, 32767, 1);
    runBatch();
  endtask

  task automatic testGappedSweep();
    // R1 with idle slots, R2 and R3 over a sweep of radii and angles
    real r, th;
    nVec = 0;
    for (int k = 0; k < 40; k++) begin
      r = 500.0 + 800.0 * real'(k);
      th = (9.3 * real'(k) + 1.0) * TWO_PI / 360.0;
      addVec($rtoi(r * $cos(th)), $rtoi(r * $sin(th)), (k % 5) != 3);
    end
    runBatch();
  endtask

  initial begin
    repeat (2) @(negedge clk);
    testReset();
    testOctants();
    testAxes();
    testZero();
    testExtremes();
    testGappedSweep();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule